// File: doc/BRIEF.md
# Page-Table Invalidate and Translation-Cache Purge Sequencer

This block tears down an I/O address mapping. One unmap request carries an I/O virtual address, a byte count and a chain-size shift. The block aligns the address down to a page boundary and rounds the byte count up to whole pages. It then walks the affected pages in ascending order. For each page it writes a zero into the one byte of the 8-byte translation-table entry that holds the valid flag. This is done through a byte-wide memory write port.

After every invalidation write has been accepted, the block waits through an ordering gap. It then sends purge commands to the translation cache through a 32-bit command write port. Purges step by the chain size, not by the page size. Each command word is a fixed opcode merged with a page-aligned address. A one-cycle done pulse closes the request, and it carries an error flag when the table walk runs past the last table entry.

Both write ports use valid/ready handshakes and can retire one write per clock. A new request is taken only while the block is idle.

Top module: `unmap_seq`

## Requirements
- R1: After reset, req_ready is 1 and mem_valid, cmd_valid, done and done_err are all 0.
- R2: The number of invalidation writes for an in-range request equals ceil(bytes / 2^PAGE_SHIFT). A zero byte count gives no writes, no purge commands, and a done pulse with done_err = 0.
- R3: The k-th invalidation write (k from 0) goes to byte address (idx0 + k) * 8 + 7 with data 0x00, where idx0 = iova >> PAGE_SHIFT. The low PAGE_SHIFT address bits have no effect.
- R4: If the walk reaches a table index at or above TABLE_ENTRIES, that write is not issued and the walk stops. Done then pulses with done_err = 1 and no purge command is issued. Writes for the in-range pages before that index still happen.
- R5: With chain = 2^chain_shift and a rounded byte count P, the purge counter starts at P + chain. One command is issued while the counter is greater than chain, and the counter drops by chain after each command. This gives ceil(P / chain) commands.
- R6: Purge command k carries the 32-bit word 33 | (base + k * chain), where base is iova with its page-offset bits cleared.
- R7: No purge command is offered until every invalidation write has been accepted. At least one further clock passes after the last write is accepted. The two ports are never valid in the same cycle.
- R8: While a port shows valid and its ready is low, valid stays high and the address or command word stays unchanged on the next cycle.
- R9: Done is a single-cycle pulse that follows the last accepted write of the request. done_err is high only together with done. req_ready is low whenever either write port is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Unmap request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_iova | input | ADDR_W | I/O virtual address of the region |
| req_bytes | input | CNT_W | Length of the region in bytes |
| req_chain_shift | input | SH_W | log2 of the purge step, PAGE_SHIFT or more |
| mem_valid | output | 1 | Invalidation write offered |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | log2(TABLE_ENTRIES)+3 | Byte address of the entry's valid byte |
| mem_data | output | 8 | Byte written (always zero) |
| cmd_valid | output | 1 | Purge command offered |
| cmd_ready | input | 1 | Cache accepts the command |
| cmd_data | output | ADDR_W | Purge opcode merged with the purge address |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Table index out of range, qualifies done |

## Verification
A page counter or index that drifts inside the walker shows up at once on the memory port. The bad write lands at the wrong byte address, or the number of accepted writes differs from the rounded page count. The bench sees this in the same request. A wrong chain count or address step in the purge engine gives a wrong command word, or one command too many or too few, before done. A sequencing fault that starts purging early shows as a command offered within one clock of the last invalidation, or as both ports valid together. The bound check is exercised by requests that start below the table end and run past it, and by requests that start beyond it.

// File: rtl/unmap_seq_pkg.sv
package unmap_seq_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_INVAL = 2'd1,
    S_FENCE = 2'd2,
    S_PURGE = 2'd3
  } seq_state_t;

  localparam int unsigned PURGE_OPCODE = 33;
endpackage

// File: rtl/unmap_inval_walk.sv
// Walks table entries one page at a time and clears each valid byte.
module unmap_inval_walk #(
  parameter  int ADDR_W     = 32,
  parameter  int PAGE_SHIFT = 12,
  parameter  int ENTRIES    = 64,
  parameter  int PG_W       = 9,
  localparam int IX_W       = ADDR_W - PAGE_SHIFT,
  localparam int TI_W       = $clog2(ENTRIES),
  localparam int MA_W       = TI_W + 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [IX_W-1:0] start_idx,
  input  logic [PG_W-1:0] start_pages,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [MA_W-1:0] mem_addr,
  output logic            fin,
  output logic            err
);
  localparam logic [IX_W-1:0] LIMIT = IX_W'(ENTRIES);

  logic            act;
  logic [IX_W-1:0] idx;
  logic [PG_W-1:0] left;
  logic            in_range;

  assign in_range  = (idx < LIMIT);
  assign mem_valid = act && (left != '0) && in_range;
  assign mem_addr  = {idx[TI_W-1:0], 3'b111};

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= 1'b0;
      idx  <= '0;
      left <= '0;
      fin  <= 1'b0;
      err  <= 1'b0;
    end else begin
      fin <= 1'b0;
      err <= 1'b0;
      if (start) begin
        act  <= 1'b1;
        idx  <= start_idx;
        left <= start_pages;
      end else if (act) begin
        if (left == '0) begin
          act <= 1'b0;
          fin <= 1'b1;
        end else if (!in_range) begin
          act <= 1'b0;
          err <= 1'b1;
        end else if (mem_ready) begin
          idx  <= idx + 1'b1;
          left <= left - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/unmap_purge_walk.sv
// Issues purge commands stepping by the chain size.
module unmap_purge_walk #(
  parameter int ADDR_W = 32,
  parameter int PC_W   = 34,
  parameter int SH_W   = 5,
  parameter int OPCODE = 33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [PC_W-1:0]   start_bytes,
  input  logic [SH_W-1:0]   start_shift,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_data,
  output logic              fin
);
  localparam logic [ADDR_W-1:0] OP_WORD = ADDR_W'(OPCODE);

  logic              act;
  logic [ADDR_W-1:0] addr;
  logic [PC_W-1:0]   cnt;
  logic [PC_W-1:0]   chain;
  logic [PC_W-1:0]   chain_n;
  logic              more;

  assign chain_n   = PC_W'(1) << start_shift;
  assign more      = (cnt > chain);
  assign cmd_valid = act && more;
  assign cmd_data  = addr | OP_WORD;

  always_ff @(posedge clk) begin
    if (rst) begin
      act   <= 1'b0;
      addr  <= '0;
      cnt   <= '0;
      chain <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        act   <= 1'b1;
        addr  <= start_addr;
        chain <= chain_n;
        cnt   <= start_bytes + chain_n;
      end else if (act) begin
        if (!more) begin
          act <= 1'b0;
          fin <= 1'b1;
        end else if (cmd_ready) begin
          addr <= addr + chain[ADDR_W-1:0];
          cnt  <= cnt - chain;
        end
      end
    end
  end
endmodule

// File: rtl/unmap_seq.sv
module unmap_seq #(
  parameter  int ADDR_W        = 32,
  parameter  int CNT_W         = 20,
  parameter  int PAGE_SHIFT    = 12,
  parameter  int TABLE_ENTRIES = 64,
  parameter  int SH_W          = 5,
  localparam int MA_W          = $clog2(TABLE_ENTRIES) + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_iova,
  input  logic [CNT_W-1:0]  req_bytes,
  input  logic [SH_W-1:0]   req_chain_shift,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [MA_W-1:0]   mem_addr,
  output logic [7:0]        mem_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_data,
  output logic              done,
  output logic              done_err
);
  import unmap_seq_pkg::*;

  localparam int RB_W = CNT_W + 1;
  localparam int PG_W = RB_W - PAGE_SHIFT;
  localparam int PC_W = ADDR_W + 2;
  localparam int IX_W = ADDR_W - PAGE_SHIFT;
  localparam logic [RB_W-1:0]   PAGE_M1  = RB_W'((1 << PAGE_SHIFT) - 1);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << PAGE_SHIFT) - 1);

  seq_state_t        state;
  logic              accept;
  logic [PG_W-1:0]   pages;
  logic [ADDR_W-1:0] base_q;
  logic [PC_W-1:0]   rounded_q;
  logic [SH_W-1:0]   shift_q;
  logic              inv_fin, inv_err, pg_fin, pg_start;

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign pages     = PG_W'((RB_W'(req_bytes) + PAGE_M1) >> PAGE_SHIFT);
  assign pg_start  = (state == S_FENCE);
  assign mem_data  = 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      base_q    <= '0;
      rounded_q <= '0;
      shift_q   <= '0;
      done      <= 1'b0;
      done_err  <= 1'b0;
    end else begin
      done     <= 1'b0;
      done_err <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          base_q    <= req_iova & ~OFF_MASK;
          rounded_q <= PC_W'(pages) << PAGE_SHIFT;
          shift_q   <= req_chain_shift;
          state     <= S_INVAL;
        end
        S_INVAL: if (inv_err) begin
          done     <= 1'b1;
          done_err <= 1'b1;
          state    <= S_IDLE;
        end else if (inv_fin) begin
          state <= S_FENCE;
        end
        S_FENCE: state <= S_PURGE;
        S_PURGE: if (pg_fin) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  unmap_inval_walk #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
    .ENTRIES(TABLE_ENTRIES), .PG_W(PG_W)
  ) u_inval (
    .clk(clk), .rst(rst), .start(accept),
    .start_idx(req_iova[ADDR_W-1:PAGE_SHIFT]), .start_pages(pages),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .fin(inv_fin), .err(inv_err)
  );

  unmap_purge_walk #(
    .ADDR_W(ADDR_W), .PC_W(PC_W), .SH_W(SH_W), .OPCODE(PURGE_OPCODE)
  ) u_purge (
    .clk(clk), .rst(rst), .start(pg_start),
    .start_addr(base_q), .start_bytes(rounded_q), .start_shift(shift_q),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .fin(pg_fin)
  );

  logic unused_ix;
  assign unused_ix = ^{IX_W'(0)};
endmodule

// File: rtl/unmap_seq_chk.sv
module unmap_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int MA_W   = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [MA_W-1:0]   mem_addr,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_data,
  input logic              done,
  input logic              done_err
);
  a_r8_mem_hold: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

  a_r7_ports_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_valid && cmd_valid));

  a_r7_gap_after_write: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ready |=> !cmd_valid);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_err_with_done: assert property (@(posedge clk) disable iff (rst)
    done_err |-> done);

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (mem_valid || cmd_valid) |-> !req_ready);
endmodule

bind unmap_seq unmap_seq_chk #(.ADDR_W(ADDR_W), .MA_W(MA_W)) u_chk (.*);

// File: tb/unmap_seq_tb.sv
module unmap_seq_tb;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam int PS     = 12;
  localparam int ENT    = 16;
  localparam int SH_W   = 5;
  localparam int MA_W   = $clog2(ENT) + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_iova = '0;
  logic [CNT_W-1:0] req_bytes = '0;
  logic [SH_W-1:0] req_chain_shift = 5'd12;
  logic mem_valid, mem_ready, cmd_valid, cmd_ready, done, done_err;
  logic [MA_W-1:0] mem_addr;
  logic [7:0] mem_data;
  logic [ADDR_W-1:0] cmd_data;

  always #10 clk = ~clk;

  unmap_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_SHIFT(PS),
              .TABLE_ENTRIES(ENT), .SH_W(SH_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_iova(req_iova), .req_bytes(req_bytes), .req_chain_shift(req_chain_shift),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .done(done), .done_err(done_err));

  // Monitor: drives ready at the falling edge and records handshakes there.
  logic [15:0] lfsr = 16'hACE1;
  int cyc = 0;
  int w_tot = 0, c_tot = 0, d_tot = 0, hold_viol = 0;
  int last_w_cyc = 0, first_c_cyc = -1, last_err = 0;
  logic [MA_W-1:0] w_addr [2048];
  logic [7:0] w_data [2048];
  logic [ADDR_W-1:0] c_word [2048];
  logic prev_mstall = 1'b0, prev_cstall = 1'b0;
  logic [MA_W-1:0] prev_maddr = '0;
  logic [ADDR_W-1:0] prev_cword = '0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = lfsr[0] | lfsr[3];
    cmd_ready = lfsr[1] | lfsr[5];
    if (!rst) begin
      if (prev_mstall && (!mem_valid || mem_addr != prev_maddr)) hold_viol <= hold_viol + 1;
      if (prev_cstall && (!cmd_valid || cmd_data != prev_cword)) hold_viol <= hold_viol + 1;
      prev_mstall = mem_valid && !mem_ready;
      prev_cstall = cmd_valid && !cmd_ready;
      prev_maddr = mem_addr;
      prev_cword = cmd_data;
      if (mem_valid && mem_ready) begin
        w_addr[w_tot & 2047] <= mem_addr;
        w_data[w_tot & 2047] <= mem_data;
        w_tot <= w_tot + 1;
        last_w_cyc <= cyc;
      end
      if (cmd_valid) begin
        if (first_c_cyc < 0) first_c_cyc <= cyc;
      end
      if (cmd_valid && cmd_ready) begin
        c_word[c_tot & 2047] <= cmd_data;
        c_tot <= c_tot + 1;
      end
      if (done) begin
        d_tot <= d_tot + 1;
        last_err <= int'(done_err);
      end
    end else begin
      mem_ready = 1'b0;
      cmd_ready = 1'b0;
    end
  end

  int errors = 0;
  int checks = 0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic run_req(input logic [ADDR_W-1:0] iova, input int bytes, input int sh);
    int w0, c0, d0, waited;
    int pages, idx0, nw, ncmd;
    logic exp_err;
    longint chain, cnt;
    logic [ADDR_W-1:0] a;
    logic [ADDR_W-1:0] exp_cmd [64];
    w0 = w_tot; c0 = c_tot; d0 = d_tot;
    first_c_cyc = -1;
    // expected values from the requirements
    pages = (bytes + (1 << PS) - 1) >> PS;
    idx0 = int'(iova >> PS);
    exp_err = 1'b0;
    nw = pages;
    if (pages > 0 && idx0 + pages > ENT) begin
      exp_err = 1'b1;
      nw = (idx0 < ENT) ? ENT - idx0 : 0;
    end
    ncmd = 0;
    if (!exp_err) begin
      chain = longint'(1) << sh;
      cnt = longint'(pages) * (1 << PS) + chain;
      a = iova & ~ADDR_W'((1 << PS) - 1);
      while (cnt > chain) begin
        exp_cmd[ncmd] = a | 32'd33;
        a = a + ADDR_W'(chain);
        cnt = cnt - chain;
        ncmd++;
      end
    end
    req_iova = iova;
    req_bytes = CNT_W'(bytes);
    req_chain_shift = SH_W'(sh);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (d_tot == d0) begin
      @(negedge clk);
      waited++;
      if (waited > 3000) begin
        errors++;
        checks++;
        $display("FAIL R9 watchdog: no done actual=0 expected=1");
        finish_run();
      end
    end
    @(negedge clk);
    chk(d_tot - d0 == 1, "R9 done pulse count", d_tot - d0, 1);
    chk(last_err == int'(exp_err), "R4 done_err", last_err, exp_err);
    chk(w_tot - w0 == nw, "R2 write count", w_tot - w0, nw);
    for (int k = 0; k < nw && k < w_tot - w0; k++) begin
      chk(w_addr[(w0 + k) & 2047] == MA_W'((idx0 + k) * 8 + 7), "R3 write address",
          w_addr[(w0 + k) & 2047], (idx0 + k) * 8 + 7);
      chk(w_data[(w0 + k) & 2047] == 8'h00, "R3 write data", w_data[(w0 + k) & 2047], 0);
    end
    chk(c_tot - c0 == ncmd, exp_err ? "R4 no purge after error" : "R5 purge count",
        c_tot - c0, ncmd);
    for (int k = 0; k < ncmd && k < c_tot - c0; k++)
      chk(c_word[(c0 + k) & 2047] == exp_cmd[k], "R6 purge word",
          c_word[(c0 + k) & 2047], exp_cmd[k]);
    if (nw > 0 && ncmd > 0)
      chk(first_c_cyc >= last_w_cyc + 2, "R7 purge after invalidation",
          first_c_cyc, last_w_cyc + 2);
    chk(hold_viol == 0, "R8 hold under backpressure", hold_viol, 0);
    chk(req_ready == 1'b1, "R9 ready after done", req_ready, 1);
  endtask

  initial begin
    int starts [5] = '{0, 3, 14, 15, 40};
    int lens [8] = '{0, 1, 4095, 4096, 4097, 8192, 12289, 20000};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset req_ready", req_ready, 1);
    chk(mem_valid == 1'b0, "R1 reset mem_valid", mem_valid, 0);
    chk(cmd_valid == 1'b0, "R1 reset cmd_valid", cmd_valid, 0);
    chk(done == 1'b0 && done_err == 1'b0, "R1 reset done", {done, done_err}, 0);
    for (int s = 0; s < 5; s++)
      for (int o = 0; o < 2; o++)
        for (int l = 0; l < 8; l++)
          for (int sh = 12; sh <= 14; sh++)
            run_req(ADDR_W'(starts[s]) << PS | ADDR_W'(o * 32'h7ff), lens[l], sh);
    // large chain step covering all pages in one command
    run_req(32'h0000_2010, 16000, 20);
    finish_run();
  end
endmodule